// File: doc/BRIEF.md
# Saturating Integer ALU with Status Flags

This block is the integer arithmetic and logic stage of a 32-bit datapath. On every cycle with a valid operation it takes two operands, an opcode and an optional immediate. It produces a registered result, a registered write strobe for the destination register and a registered five-bit status word. The status word is held inside the block, and every operation that does not touch a given flag leaves that flag as it was.

The arithmetic group covers add, subtract, reverse subtract and compare, plus saturating add, saturating subtract and saturating reverse subtract. The saturating forms clamp an overflowing result to the largest or smallest signed value. The direction of the clamp comes from the sign of the exact result. They also raise a sticky saturation flag that only reset clears. The logic group covers AND, OR, XOR, NOT and a test operation. When immediate mode is selected, an extended immediate replaces the first operand. The extension can be 5-bit signed, 16-bit signed or 16-bit zero.

Results appear one clock after the operation is sampled. The write strobe is high for exactly that one cycle.

Top module: `sat_flag_alu`

## Requirements
- R1: Synchronous active-high reset clears `res_q` to zero, `wr_q` to 0 and all five status bits. The status bits are `flg_q[0]`=Z, `[1]`=S, `[2]`=CY, `[3]`=OV and `[4]`=SAT.
- R2: Opcode 0 (add) writes A+B, where A is the first operand and B is `opnd_b`. CY is the unsigned carry out. OV is set when A and B share a sign and the result does not. Z is set when the result is zero, and S is bit 31 of the result. SAT is unchanged.
- R3: Opcode 1 (subtract) writes B−A and opcode 2 (reverse subtract) writes A−B. CY is the unsigned borrow, meaning the minuend is below the subtrahend. OV is set when the exact signed difference does not fit in 32 bits. Z and S are taken from the result.
- R4: Opcode 3 (compare) updates Z, S, CY and OV exactly as subtract would. It keeps `wr_q` at 0, and `res_q` keeps its previous value.
- R5: Opcodes 4, 5 and 6 (saturating add, subtract and reverse subtract) compute the same values as opcodes 0, 1 and 2. On overflow the written value is 0x7FFFFFFF when the exact result is positive and 0x80000000 when it is negative. Z and S are taken from the written value, and CY and OV are as for the plain forms.
- R6: SAT is set by an overflow in opcodes 4 to 6. No operation clears it; only reset does.
- R7: Opcodes 7 to 10 write A&B, A|B, A^B and ~A. Z and S are taken from the result, OV is cleared, and CY and SAT are unchanged.
- R8: Opcode 11 (test) sets Z and S from A&B and clears OV. It keeps CY, writes nothing, and `res_q` is held.
- R9: When `use_imm`=1, the first operand A is the extended immediate. Kind 0 sign-extends `imm[4:0]`, kind 1 sign-extends `imm[15:0]`, and kinds 2 and 3 zero-extend `imm[15:0]`.
- R10: AND (opcode 7) with a 16-bit immediate (kind 1, 2 or 3) sets Z from the result and forces S to 0.
- R11: A cycle with `in_valid`=0, or with an opcode from 12 to 15, writes nothing and leaves `res_q` and all flags unchanged.
- R12: An operation sampled at a rising edge shows its result and flags only after that edge, and `wr_q` is high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opc | input | 4 | Operation code |
| opnd_a | input | W | First operand (register) |
| opnd_b | input | W | Second operand |
| use_imm | input | 1 | Replace first operand with extended immediate |
| imm_kind | input | 2 | Immediate extension kind |
| imm | input | IMM_W | Raw immediate field |
| res_q | output | W | Registered result |
| wr_q | output | 1 | Registered destination write strobe |
| flg_q | output | 5 | Status word {SAT, OV, CY, S, Z} |

## Verification
The interaction that needs the most care is clamping and flag derivation landing in the same cycle. A saturating operation that overflows must report Z and S from the clamped value rather than the wrapped sum, and it must raise the sticky SAT bit in the same update. The bench provokes this by sweeping every opcode over operand pairs built from the signed extremes (0x7FFFFFFF, 0x80000000, 0x80000001, −1, −2) and small values, so positive and negative overflow both occur in all three saturating forms. Each outcome is compared against an exact 64-bit signed model. The SAT bit is checked after every later operation to confirm that no plain or logic operation clears it.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  localparam logic [3:0] OPC_ADD   = 4'd0;
  localparam logic [3:0] OPC_SUB   = 4'd1;
  localparam logic [3:0] OPC_RSUB  = 4'd2;
  localparam logic [3:0] OPC_CMP   = 4'd3;
  localparam logic [3:0] OPC_SADD  = 4'd4;
  localparam logic [3:0] OPC_SSUB  = 4'd5;
  localparam logic [3:0] OPC_SRSUB = 4'd6;
  localparam logic [3:0] OPC_AND   = 4'd7;
  localparam logic [3:0] OPC_OR    = 4'd8;
  localparam logic [3:0] OPC_XOR   = 4'd9;
  localparam logic [3:0] OPC_NOT   = 4'd10;
  localparam logic [3:0] OPC_TST   = 4'd11;

  localparam logic [1:0] IMK_S5  = 2'd0;
  localparam logic [1:0] IMK_S16 = 2'd1;

  localparam logic [1:0] LF_AND = 2'd0;
  localparam logic [1:0] LF_OR  = 2'd1;
  localparam logic [1:0] LF_XOR = 2'd2;
  localparam logic [1:0] LF_NOT = 2'd3;

  typedef struct packed {
    logic sat;
    logic ov;
    logic cy;
    logic s;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/sat_alu_immext.sv
module sat_alu_immext
  import sat_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic [1:0]       kind,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     val
);
  localparam int SHORT_PAD = W - SIMM_W;
  localparam int LONG_PAD  = W - IMM_W;

  always_comb begin
    case (kind)
      IMK_S5:  val = {{SHORT_PAD{imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
      IMK_S16: val = {{LONG_PAD{imm[IMM_W-1]}}, imm};
      default: val = {{LONG_PAD{1'b0}}, imm};
    endcase
  end
endmodule

// File: rtl/sat_alu_addsub.sv
module sat_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic [W-1:0] clamp,
  output logic         cy,
  output logic         ov
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  always_comb begin
    y_eff = sub ? ~y : y;
    wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    // carry out for add, borrow for subtract
    cy    = wide[W] ^ sub;
    ov    = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    // on overflow the exact result carries the sign of x
    clamp = x[W-1] ? NEG_LIM : POS_LIM;
  end
endmodule

// File: rtl/sat_alu_logic.sv
module sat_alu_logic
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   fn,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] r
);
  always_comb begin
    case (fn)
      LF_AND:  r = x & y;
      LF_OR:   r = x | y;
      LF_XOR:  r = x ^ y;
      default: r = ~x;
    endcase
  end
endmodule

// File: rtl/sat_flag_alu.sv
module sat_flag_alu
  import sat_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       opc,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             use_imm,
  input  logic [1:0]       imm_kind,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     res_q,
  output logic             wr_q,
  output logic [4:0]       flg_q
);
  alu_flags_t   cur_f, nxt_f;
  logic [W-1:0] imm_val, op_first;
  logic [W-1:0] ax, ay, a_sum, a_clamp, a_final;
  logic         a_sub, a_cy, a_ov;
  logic [1:0]   l_fn;
  logic [W-1:0] l_res;
  logic [W-1:0] res_n;
  logic         wr_n;
  logic         and_imm16;

  sat_alu_immext #(.W(W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_imm (
    .kind (imm_kind),
    .imm  (imm),
    .val  (imm_val)
  );

  assign op_first  = use_imm ? imm_val : opnd_a;
  assign and_imm16 = use_imm && (imm_kind != IMK_S5);

  // operand routing: forward forms subtract the first operand from the second
  always_comb begin
    a_sub = !((opc == OPC_ADD) || (opc == OPC_SADD));
    if ((opc == OPC_SUB) || (opc == OPC_CMP) || (opc == OPC_SSUB)) begin
      ax = opnd_b;
      ay = op_first;
    end else begin
      ax = op_first;
      ay = opnd_b;
    end
  end

  sat_alu_addsub #(.W(W)) u_arith (
    .x     (ax),
    .y     (ay),
    .sub   (a_sub),
    .sum   (a_sum),
    .clamp (a_clamp),
    .cy    (a_cy),
    .ov    (a_ov)
  );

  always_comb begin
    case (opc)
      OPC_OR:  l_fn = LF_OR;
      OPC_XOR: l_fn = LF_XOR;
      OPC_NOT: l_fn = LF_NOT;
      default: l_fn = LF_AND;
    endcase
  end

  sat_alu_logic #(.W(W)) u_logic (
    .fn (l_fn),
    .x  (op_first),
    .y  (opnd_b),
    .r  (l_res)
  );

  assign a_final = a_ov ? a_clamp : a_sum;

  always_comb begin
    nxt_f = cur_f;
    res_n = res_q;
    wr_n  = 1'b0;
    if (in_valid) begin
      case (opc)
        OPC_ADD, OPC_SUB, OPC_RSUB, OPC_CMP: begin
          nxt_f.z  = (a_sum == '0);
          nxt_f.s  = a_sum[W-1];
          nxt_f.cy = a_cy;
          nxt_f.ov = a_ov;
          if (opc != OPC_CMP) begin
            res_n = a_sum;
            wr_n  = 1'b1;
          end
        end
        OPC_SADD, OPC_SSUB, OPC_SRSUB: begin
          nxt_f.z   = (a_final == '0);
          nxt_f.s   = a_final[W-1];
          nxt_f.cy  = a_cy;
          nxt_f.ov  = a_ov;
          nxt_f.sat = cur_f.sat | a_ov;
          res_n     = a_final;
          wr_n      = 1'b1;
        end
        OPC_AND, OPC_OR, OPC_XOR, OPC_NOT, OPC_TST: begin
          nxt_f.z  = (l_res == '0);
          nxt_f.s  = (opc == OPC_AND && and_imm16) ? 1'b0 : l_res[W-1];
          nxt_f.ov = 1'b0;
          if (opc != OPC_TST) begin
            res_n = l_res;
            wr_n  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_f <= '0;
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      cur_f <= nxt_f;
      res_q <= res_n;
      wr_q  <= wr_n;
    end
  end

  assign flg_q = cur_f;
endmodule

// File: rtl/sat_flag_alu_chk.sv
module sat_flag_alu_chk
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   opc,
  input logic         use_imm,
  input logic [1:0]   imm_kind,
  input logic [W-1:0] res_q,
  input logic         wr_q,
  input logic [4:0]   flg_q
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  assert_sign_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc <= OPC_SRSUB && opc != OPC_CMP) |=> (flg_q[1] == res_q[W-1]));

  assert_cmp_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc == OPC_CMP) |=> (!wr_q && $stable(res_q)));

  assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opc == OPC_SADD || opc == OPC_SSUB || opc == OPC_SRSUB))
    |=> (!flg_q[3] || res_q == POS_LIM || res_q == NEG_LIM));

  assert_sat_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    flg_q[4] |=> flg_q[4]);

  assert_logic_keeps_cy_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc >= OPC_AND && opc <= OPC_TST)
    |=> (flg_q[2] == $past(flg_q[2]) && !flg_q[3]));

  assert_tst_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc == OPC_TST) |=> (!wr_q && $stable(res_q)));

  assert_andimm_sign_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc == OPC_AND && use_imm && imm_kind != IMK_S5) |=> !flg_q[1]);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || opc > OPC_TST) |=> (!wr_q && $stable(flg_q) && $stable(res_q)));
endmodule

bind sat_flag_alu sat_flag_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .opc      (opc),
  .use_imm  (use_imm),
  .imm_kind (imm_kind),
  .res_q    (res_q),
  .wr_q     (wr_q),
  .flg_q    (flg_q)
);

// File: tb/sat_flag_alu_test.sv
`timescale 1ns/1ps
module sat_flag_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  opc = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        use_imm = 1'b0;
  logic [1:0]  imm_kind = '0;
  logic [15:0] imm = '0;
  logic [31:0] res_q;
  logic        wr_q;
  logic [4:0]  flg_q;

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 0;

  logic [31:0] m_res = '0;
  logic [4:0]  m_flg = '0; // {sat, ov, cy, s, z}

  always #10 clk = ~clk;

  sat_flag_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opc(opc),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .use_imm(use_imm),
    .imm_kind(imm_kind), .imm(imm),
    .res_q(res_q), .wr_q(wr_q), .flg_q(flg_q)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] opval(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'hFFFF_FFFF;
      7: return 32'h1234_5678;
      default: return 32'hFFFF_FFFE;
    endcase
  endfunction

  function automatic logic [15:0] immval(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h001F;
      2: return 16'h0010;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'h7FFF;
    endcase
  endfunction

  function automatic logic [31:0] ext_imm(input logic [1:0] k, input logic [15:0] v);
    if (k == 2'd0) return {{27{v[4]}}, v[4:0]};
    if (k == 2'd1) return {{16{v[15]}}, v};
    return {16'h0000, v};
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    if (o == 0) return "R2";
    if (o == 1 || o == 2) return "R3";
    if (o == 3) return "R4";
    if (o >= 4 && o <= 6) return "R5";
    if (o >= 7 && o <= 10) return "R7";
    if (o == 11) return "R8";
    return "R11";
  endfunction

  // Drive at a falling edge, let one rising edge sample it, check at the next falling edge.
  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic ui, input logic [1:0] k, input logic [15:0] im, input logic v);
    logic [31:0] first, x, y, r, lr;
    logic [63:0] ux;
    longint      t;
    logic        is_sub, cy, ov, exp_wr;
    logic [4:0]  nf;
    string       tg, ftg, rtg;
    opc = o; opnd_a = a; opnd_b = b; use_imm = ui; imm_kind = k; imm = im; in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;

    first  = ui ? ext_imm(k, im) : a;
    nf     = m_flg;
    r      = m_res;
    exp_wr = 1'b0;
    tg     = v ? op_tag(o) : "R11";
    if (v && o <= 6) begin
      is_sub = !(o == 0 || o == 4);
      if (o == 1 || o == 3 || o == 5) begin x = b; y = first; end
      else begin x = first; y = b; end
      if (is_sub) begin
        t  = longint'($signed(x)) - longint'($signed(y));
        cy = (x < y);
      end else begin
        t  = longint'($signed(x)) + longint'($signed(y));
        ux = {32'h0, x} + {32'h0, y};
        cy = ux[32];
      end
      ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      lr = t[31:0];
      if (o >= 4 && ov) lr = (t > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      nf[0] = (lr == 0);
      nf[1] = lr[31];
      nf[2] = cy;
      nf[3] = ov;
      if (o >= 4) nf[4] = m_flg[4] | ov;
      if (o != 3) begin r = lr; exp_wr = 1'b1; end
    end else if (v && o <= 11) begin
      case (o)
        4'd8:    lr = first | b;
        4'd9:    lr = first ^ b;
        4'd10:   lr = ~first;
        default: lr = first & b;
      endcase
      nf[0] = (lr == 0);
      nf[1] = (o == 7 && ui && k != 0) ? 1'b0 : lr[31];
      nf[3] = 1'b0;
      if (o != 11) begin r = lr; exp_wr = 1'b1; end
    end
    m_flg = nf;
    m_res = r;

    ftg = (v && o == 7 && ui && k != 0) ? "R10" : tg;
    rtg = (v && ui && o <= 10 && o != 3) ? "R9" : tg;
    chk(rtg, "result", res_q, m_res);
    chk(tg, "write", {31'h0, wr_q}, {31'h0, exp_wr});
    chk(ftg, "flags", {27'h0, flg_q}, {27'h0, m_flg});
    chk("R6", "sat", {31'h0, flg_q[4]}, {31'h0, m_flg[4]});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset result", res_q, 32'h0);
    chk("R1", "reset write", {31'h0, wr_q}, 32'h0);
    chk("R1", "reset flags", {27'h0, flg_q}, 32'h0);

    // latency: nothing visible before the sampling edge
    opc = 4'd0; opnd_a = 32'd5; opnd_b = 32'd7; use_imm = 1'b0; in_valid = 1'b1;
    #5;
    chk("R12", "before edge result", res_q, 32'h0);
    chk("R12", "before edge write", {31'h0, wr_q}, 32'h0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", "after edge result", res_q, 32'd12);
    chk("R12", "after edge write", {31'h0, wr_q}, 32'h1);
    @(negedge clk);
    chk("R12", "strobe one cycle", {31'h0, wr_q}, 32'h0);
    m_res = 32'd12;
    m_flg = 5'b0;

    // register-operand sweep across all opcodes, including undefined ones
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int o = 0; o < 16; o++)
          run_op(4'(o), opval(i), opval(j), 1'b0, 2'd0, 16'h0, 1'b1);

    // idle cycles with a live opcode present
    run_op(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 2'd0, 16'h0, 1'b0);
    run_op(4'd7, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 1'b0);

    // reset clears the sticky bit and results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "re-reset result", res_q, 32'h0);
    chk("R1", "re-reset flags", {27'h0, flg_q}, 32'h0);
    m_res = '0;
    m_flg = '0;

    // immediate sweep over every extension kind
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 6; m++)
        for (int j = 0; j < 9; j++) begin
          run_op(4'd0,  32'hDEAD_BEEF, opval(j), 1'b1, 2'(k), immval(m), 1'b1);
          run_op(4'd5,  32'hDEAD_BEEF, opval(j), 1'b1, 2'(k), immval(m), 1'b1);
          run_op(4'd7,  32'hDEAD_BEEF, opval(j), 1'b1, 2'(k), immval(m), 1'b1);
          run_op(4'd8,  32'hDEAD_BEEF, opval(j), 1'b1, 2'(k), immval(m), 1'b1);
          run_op(4'd3,  32'hDEAD_BEEF, opval(j), 1'b1, 2'(k), immval(m), 1'b1);
        end

    finish_run();
  end
endmodule